// File: doc/BRIEF.md
# SIMD Broadcast Element Loader

This block carries out the vector structure-load form that fetches a single element from memory and copies it into every lane of one or more 64-bit destination registers. An instruction is presented with its decoded field slice, a base address, a destination register index and a load/store flag. The block first checks the encoding. If the encoding is illegal, it reports the instruction as undefined and touches nothing.

For a legal encoding, the block issues one memory read per element, with only one read in flight at a time. Each returned element is widened to a 32-bit word by repetition, and that word is placed in both halves of the destination register through the register-file write port.

Bit 5 of the instruction changes meaning with the register count. With one register it asks for a second, adjacent copy. With two to four registers it sets the destination stride. On completion the block reports the number of bytes the address advanced.

Top module: `simd_bcast_load`

## Requirements
- R1: `in_fld` carries instruction bits 9:4. `in_fld[5:4]` (bits 9:8) plus one is the register count. `in_fld[3:2]` (bits 7:6) is the size code: 0 = byte, 1 = halfword, 2 = word. `in_fld[1]` (bit 5) is the pair/stride flag. `in_fld[0]` (bit 4) is the alignment flag.
- R2: When `in_is_load` is 0, the instruction completes with `undef`=1. No memory read is issued and no register write occurs.
- R3: Size code 3 is accepted only with a count of 4 and the alignment flag set. It then executes as word elements (`mem_req_size`=2 and a 4-byte step). Every other use of size code 3 is undefined.
- R4: A count of 1 with the alignment flag set and byte size is undefined. A count of 3 with the alignment flag set is undefined.
- R5: For an undefined encoding, `done` and `undef` are high together for one cycle. This happens in the second cycle after the accepting clock edge, and no read request is ever raised.
- R6: Only the low bits of `mem_rsp_data` are used. A byte is zero-extended and repeated into all four byte lanes of a word. A halfword is repeated into both 16-bit halves. A word is used unchanged. `rf_data` holds that word in both of its 32-bit halves.
- R7: With a count of 1, exactly one read is made, at the base address. The result is written to `in_rd`. When the pair flag is set, the same value is also written to `in_rd`+1 in the following cycle.
- R8: With counts 2 to 4, read k (k counting from 0) goes to base + k·2^size. Its result is written to `in_rd` + k·s, where s is 2 when the pair flag is set and 1 otherwise. `mem_req_size` gives the effective size code.
- R9: Destination indices wrap modulo 32.
- R10: During the `done` cycle, `addr_adv` equals 2^size × count, using the effective size. It is 0 for an undefined encoding.
- R11: At most one read is outstanding. Each fetched register is written in the cycle after its response arrives, and the pair copy is written in the cycle right after that.
- R12: `in_ready` is high after reset. It falls in the cycle after acceptance and stays low until it returns high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle and able to accept |
| in_fld | input | 6 | Instruction bits 9:4 (count, size, pair, align) |
| in_is_load | input | 1 | 1 = load, 0 = store |
| in_base | input | ADDR_W | Base address |
| in_rd | input | IDX_W | First destination register |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | ADDR_W | Read address |
| mem_req_size | output | 2 | Effective element size code |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | WORD_W | Read data, element in low bits |
| rf_we | output | 1 | Register write strobe |
| rf_idx | output | IDX_W | Register index written |
| rf_data | output | 2*WORD_W | Replicated 64-bit value |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Completion was an undefined encoding |
| addr_adv | output | 5 | Total address advance, valid with done |

## Verification
The assertions assume a memory side that returns exactly one response for each request, never before the request, and never without one pending. They also assume that `in_valid` is held off while `in_ready` is low. The bench's memory model meets these assumptions: it latches each request and answers it after a chosen latency of one to three cycles. The bench also presents a new instruction only after the previous `done`. The sweep visits every combination of load flag, size code, count, alignment and pair flag. It varies the first register so that several runs cross index 31.

// File: rtl/simd_bcast_load_pkg.sv
package simd_bcast_load_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } elem_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DUP   = 2'd3
  } seq_state_e;

  // Field slice: instruction bits 9:4 packed MSB-first
  typedef struct packed {
    logic [1:0] cnt_m1;  // bits 9:8
    elem_size_e size;    // bits 7:6
    logic       pair;    // bit 5
    logic       align;   // bit 4
  } ld_fields_t;

  localparam int FLD_W = 6;
  localparam int ADV_W = 5;

endpackage

// File: rtl/simd_bcast_load_decode.sv
module simd_bcast_load_decode
  import simd_bcast_load_pkg::*;
(
  input  ld_fields_t fld,
  input  logic       is_load,
  output logic       bad,
  output elem_size_e eff_size,
  output logic [2:0] count,
  output logic       single,
  output logic [1:0] stride
);

  always_comb begin
    count    = {1'b0, fld.cnt_m1} + 3'd1;
    single   = (fld.cnt_m1 == 2'd0);
    stride   = fld.pair ? 2'd2 : 2'd1;
    eff_size = (fld.size == SZ_WIDE) ? SZ_WORD : fld.size;
    bad      = !is_load;
    if (fld.size == SZ_WIDE && !(fld.cnt_m1 == 2'd3 && fld.align))
      bad = 1'b1;
    if (fld.cnt_m1 == 2'd0 && fld.align && fld.size == SZ_BYTE)
      bad = 1'b1;
    if (fld.cnt_m1 == 2'd2 && fld.align)
      bad = 1'b1;
  end

endmodule

// File: rtl/simd_bcast_load_repl.sv
module simd_bcast_load_repl
  import simd_bcast_load_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int REG_W  = 2 * WORD_W
) (
  input  elem_size_e          size,
  input  logic [WORD_W-1:0]   din,
  output logic [REG_W-1:0]    dout
);

  localparam int N_BYTES = WORD_W / 8;
  localparam int N_HALFS = WORD_W / 16;
  localparam int N_WORDS = REG_W / WORD_W;

  logic [WORD_W-1:0] word;

  always_comb begin
    word = din;
    case (size)
      SZ_BYTE: for (int i = 0; i < N_BYTES; i++) word[i*8 +: 8] = din[7:0];
      SZ_HALF: for (int i = 0; i < N_HALFS; i++) word[i*16 +: 16] = din[15:0];
      default: word = din;
    endcase
  end

  for (genvar j = 0; j < N_WORDS; j++) begin : g_copy
    assign dout[j*WORD_W +: WORD_W] = word;
  end

endmodule

// File: rtl/simd_bcast_load_step.sv
module simd_bcast_load_step
  import simd_bcast_load_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        stride,
  input  elem_size_e        size,
  output logic [IDX_W-1:0]  idx_next,
  output logic [IDX_W-1:0]  idx_adj,
  output logic [ADDR_W-1:0] addr_next
);

  // index arithmetic wraps at 2**IDX_W by width
  assign idx_next  = idx + IDX_W'(stride);
  assign idx_adj   = idx + IDX_W'(1);
  assign addr_next = addr + (ADDR_W'(1) << size);

endmodule

// File: rtl/simd_bcast_load.sv
module simd_bcast_load
  import simd_bcast_load_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [FLD_W-1:0]    in_fld,
  input  logic                in_is_load,
  input  logic [ADDR_W-1:0]   in_base,
  input  logic [IDX_W-1:0]    in_rd,
  output logic                mem_req_valid,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [1:0]          mem_req_size,
  input  logic                mem_rsp_valid,
  input  logic [WORD_W-1:0]   mem_rsp_data,
  output logic                rf_we,
  output logic [IDX_W-1:0]    rf_idx,
  output logic [2*WORD_W-1:0] rf_data,
  output logic                done,
  output logic                undef,
  output logic [ADV_W-1:0]    addr_adv
);

  localparam int REG_W = 2 * WORD_W;

  seq_state_e        state;
  ld_fields_t        fld_q;
  logic              load_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  rd_q;
  logic [IDX_W-1:0]  cur_idx;
  logic [1:0]        k_q;

  logic              dec_bad;
  elem_size_e        dec_size;
  logic [2:0]        dec_count;
  logic              dec_single;
  logic [1:0]        dec_stride;
  logic [REG_W-1:0]  rep_data;
  logic [IDX_W-1:0]  idx_next;
  logic [IDX_W-1:0]  idx_adj;
  logic [ADDR_W-1:0] addr_next;
  logic [ADV_W-1:0]  adv_val;
  logic              accept;
  logic              last_elem;

  simd_bcast_load_decode u_dec (
    .fld      (fld_q),
    .is_load  (load_q),
    .bad      (dec_bad),
    .eff_size (dec_size),
    .count    (dec_count),
    .single   (dec_single),
    .stride   (dec_stride)
  );

  simd_bcast_load_repl #(.WORD_W(WORD_W), .REG_W(REG_W)) u_repl (
    .size (dec_size),
    .din  (mem_rsp_data),
    .dout (rep_data)
  );

  simd_bcast_load_step #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_step (
    .idx       (cur_idx),
    .addr      (mem_req_addr),
    .stride    (dec_stride),
    .size      (dec_size),
    .idx_next  (idx_next),
    .idx_adj   (idx_adj),
    .addr_next (addr_next)
  );

  assign accept    = in_valid && in_ready;
  assign last_elem = (k_q == fld_q.cnt_m1);
  assign adv_val   = ADV_W'(dec_count) << dec_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      in_ready      <= 1'b1;
      fld_q         <= '0;
      load_q        <= 1'b0;
      base_q        <= '0;
      rd_q          <= '0;
      cur_idx       <= '0;
      k_q           <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_size  <= '0;
      rf_we         <= 1'b0;
      rf_idx        <= '0;
      rf_data       <= '0;
      done          <= 1'b0;
      undef         <= 1'b0;
      addr_adv      <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      rf_we         <= 1'b0;
      done          <= 1'b0;
      undef         <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            fld_q    <= ld_fields_t'(in_fld);
            load_q   <= in_is_load;
            base_q   <= in_base;
            rd_q     <= in_rd;
            in_ready <= 1'b0;
            state    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (dec_bad) begin
            done     <= 1'b1;
            undef    <= 1'b1;
            addr_adv <= '0;
            in_ready <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= base_q;
            mem_req_size  <= dec_size;
            cur_idx       <= rd_q;
            k_q           <= '0;
            state         <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rf_we   <= 1'b1;
            rf_idx  <= cur_idx;
            rf_data <= rep_data;
            if (dec_single && fld_q.pair) begin
              state <= ST_DUP;
            end else if (last_elem) begin
              done     <= 1'b1;
              addr_adv <= adv_val;
              in_ready <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              k_q           <= k_q + 2'd1;
              cur_idx       <= idx_next;
              mem_req_addr  <= addr_next;
              mem_req_valid <= 1'b1;
            end
          end
        end
        ST_DUP: begin
          rf_we    <= 1'b1;
          rf_idx   <= idx_adj;
          done     <= 1'b1;
          addr_adv <= adv_val;
          in_ready <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/simd_bcast_load_chk.sv
module simd_bcast_load_chk #(
  parameter int REG_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             mem_req_valid,
  input logic             mem_rsp_valid,
  input logic             rf_we,
  input logic [REG_W-1:0] rf_data,
  input logic             done,
  input logic             undef
);

  localparam int HALF = REG_W / 2;

  logic outst;
  logic req_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst    <= 1'b0;
      req_seen <= 1'b0;
    end else begin
      if (mem_req_valid) outst <= 1'b1;
      else if (mem_rsp_valid) outst <= 1'b0;
      if (in_valid && in_ready) req_seen <= 1'b0;
      else if (mem_req_valid) req_seen <= 1'b1;
    end
  end

  // R12
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R12
  ready_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready);
  // R11
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !outst);
  // R11
  write_follows_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ($past(mem_rsp_valid) || $past(rf_we)));
  // R5
  undef_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    undef |-> done);
  // R2
  undef_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    undef |-> (!req_seen && !rf_we));
  // R6
  halves_match_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_data[REG_W-1:HALF] == rf_data[HALF-1:0]));

endmodule

bind simd_bcast_load simd_bcast_load_chk #(.REG_W(2*WORD_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .mem_req_valid (mem_req_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .rf_we         (rf_we),
  .rf_data       (rf_data),
  .done          (done),
  .undef         (undef)
);

// File: tb/simd_bcast_load_bench.sv
`timescale 1ns/1ps
module simd_bcast_load_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_fld = '0;
  logic        in_is_load = 1'b0;
  logic [31:0] in_base = '0;
  logic [4:0]  in_rd = '0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rf_we;
  logic [4:0]  rf_idx;
  logic [63:0] rf_data;
  logic        done;
  logic        undef;
  logic [4:0]  addr_adv;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_total = 0;

  int          rsp_lat = 1;
  int          pend = 0;
  logic [31:0] paddr = '0;
  int          n_req = 0;
  int          n_wr = 0;
  logic [31:0] req_addr_log [0:7];
  logic [1:0]  req_size_log [0:7];
  logic [4:0]  wr_idx_log   [0:7];
  logic [63:0] wr_data_log  [0:7];

  simd_bcast_load u_simd_bcast_load (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_fld(in_fld), .in_is_load(in_is_load), .in_base(in_base), .in_rd(in_rd),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_data(rf_data), .done(done), .undef(undef), .addr_adv(addr_adv)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5AF00F;
  endfunction

  function automatic logic [63:0] expect_reg(input logic [31:0] raw, input int esz);
    logic [31:0] w;
    if (esz == 0)      w = {24'd0, raw[7:0]} * 32'h01010101;
    else if (esz == 1) w = {16'd0, raw[15:0]} * 32'h00010001;
    else               w = raw;
    return {w, w};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model and output monitor
  always @(negedge clk) begin
    cyc_total++;
    if (rf_we && n_wr < 8) begin
      wr_idx_log[n_wr]  = rf_idx;
      wr_data_log[n_wr] = rf_data;
      n_wr++;
    end
    mem_rsp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_val(paddr);
      end
    end
    if (mem_req_valid) begin
      if (n_req < 8) begin
        req_addr_log[n_req] = mem_req_addr;
        req_size_log[n_req] = mem_req_size;
      end
      n_req++;
      paddr = mem_req_addr;
      pend  = rsp_lat;
    end
  end

  task automatic run_one(input bit ld, input int sz, input int cm, input int al,
                         input int pr, input int rd, input logic [31:0] base,
                         input int lat);
    bit   exp_undef;
    int   esz, cnt, exp_nreq, exp_nwr, cyc;
    bit   seen;
    logic [4:0] got_adv;
    logic got_undef;
    logic [4:0]  e_idx [0:7];
    logic [31:0] e_addr [0:7];
    logic [63:0] e_data [0:7];
    cnt = cm + 1;
    esz = (sz == 3) ? 2 : sz;
    // R2 R3 R4: legality
    exp_undef = !ld || (sz == 3 && !(cnt == 4 && al == 1)) ||
                (cnt == 1 && al == 1 && sz == 0) || (cnt == 3 && al == 1);
    exp_nreq = 0; exp_nwr = 0;
    if (!exp_undef) begin
      exp_nreq = cnt;
      if (cnt == 1) begin
        // R7
        e_addr[0] = base;
        e_idx[0]  = 5'(rd);
        e_data[0] = expect_reg(mem_val(base), esz);
        exp_nwr   = 1;
        if (pr == 1) begin
          e_idx[1]  = 5'((rd + 1) % 32);
          e_data[1] = e_data[0];
          exp_nwr   = 2;
        end
      end else begin
        // R8 R9
        exp_nwr = cnt;
        for (int k = 0; k < cnt; k++) begin
          e_addr[k] = base + 32'(k * (1 << esz));
          e_idx[k]  = 5'((rd + k * (pr == 1 ? 2 : 1)) % 32);
          e_data[k] = expect_reg(mem_val(e_addr[k]), esz);
        end
      end
    end
    @(negedge clk);
    n_req = 0; n_wr = 0; rsp_lat = lat;
    in_fld     = {2'(cm), 2'(sz), 1'(pr), 1'(al)};
    in_is_load = ld;
    in_base    = base;
    in_rd      = 5'(rd);
    in_valid   = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    cyc = 0; seen = 0; got_adv = '0; got_undef = 1'b0;
    while (!seen && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) chk(in_ready == 1'b0, "R12 ready low while busy", 64'(in_ready), 64'd0);
      if (done) begin
        seen = 1;
        got_adv = addr_adv;
        got_undef = undef;
        chk(in_ready == 1'b1, "R12 ready with done", 64'(in_ready), 64'd1);
      end
    end
    chk(seen, "R12 completion seen", 64'(seen), 64'd1);
    @(posedge clk);
    #1;
    chk(got_undef == exp_undef, "R2/R3/R4 undef flag", 64'(got_undef), 64'(exp_undef));
    if (exp_undef) chk(cyc == 2, "R5 undef latency", 64'(cyc), 64'd2);
    chk(n_req == exp_nreq, "R5/R7/R8 read count", 64'(n_req), 64'(exp_nreq));
    chk(n_wr == exp_nwr, "R2/R7/R8 write count", 64'(n_wr), 64'(exp_nwr));
    // R10
    chk(got_adv == (exp_undef ? 5'd0 : 5'(cnt << esz)), "R10 address advance",
        64'(got_adv), 64'(exp_undef ? 0 : (cnt << esz)));
    if (n_req == exp_nreq)
      for (int k = 0; k < exp_nreq; k++) begin
        chk(req_addr_log[k] == e_addr[k], "R8 read address", 64'(req_addr_log[k]), 64'(e_addr[k]));
        chk(req_size_log[k] == 2'(esz), "R3 effective size", 64'(req_size_log[k]), 64'(esz));
      end
    if (n_wr == exp_nwr)
      for (int k = 0; k < exp_nwr; k++) begin
        chk(wr_idx_log[k] == e_idx[k], "R9 destination index", 64'(wr_idx_log[k]), 64'(e_idx[k]));
        chk(wr_data_log[k] == e_data[k], "R6 replicated data", wr_data_log[k], e_data[k]);
      end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R12 reset ready", 64'(in_ready), 64'd1);
    chk(done == 1'b0 && rf_we == 1'b0 && mem_req_valid == 1'b0, "R12 reset idle outputs",
        64'({done, rf_we, mem_req_valid}), 64'd0);
    // R1: full sweep of field values
    for (int idx = 0; idx < 128; idx++) begin
      run_one(idx[6], idx[5:4], idx[3:2], idx[1], idx[0],
              (idx * 7 + 27) % 32, 32'h1000_0000 + 32'(idx * 64 + idx % 5), 1 + idx % 3);
    end
    // R9 wrap with stride 2 from the last register
    run_one(1'b1, 2, 3, 0, 1, 31, 32'h2000_0010, 2);
    // R7 pair copy crossing index 31
    run_one(1'b1, 1, 0, 1, 1, 31, 32'h3000_0002, 3);
    // R3 wide size legal form
    run_one(1'b1, 3, 3, 1, 0, 30, 32'h4000_0000, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc_total > 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc_total);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule